// File: doc/BRIEF.md
# Short-Cycle SAR Conversion Sequencer

This block sequences a successive-approximation conversion for a data converter whose DAC, comparator and timing oscillator live outside it. A one-cycle start pulse begins a conversion. The length-select bit is captured with that pulse, and it chooses between a full 12-bit run and a shortened 8-bit run. The sequencer places a trial code on its DAC port and decides one bit per step, beginning with the most significant bit. In each step it reads the comparator input on the final clock cycle only. A set comparator input means the analog input is at or above the DAC level, so the trial bit is kept.

While a conversion runs, a busy output is held high. When the last decision of the selected length completes, the code is copied into the result register and busy drops. Two one-cycle pulses tell the read logic when the upper eight bits are final and when all twelve bits are final. A shortened run leaves a fixed residue in the four low bits that were never converted. Start requests that arrive during a conversion have no effect.

Top module: `sar_seq`

## Requirements
- R1: After synchronous reset, busy, both end pulses, the DAC code and the result register are all zero.
- R2: A start with length-select low runs 12 decisions and holds busy high for exactly 12*STEP_CYCLES cycles. The result equals the largest code whose DAC level does not exceed the analog input.
- R3: The first trial code presented after a start is 0x800, with only bit 11 set. Bits are decided in order from bit 11 down.
- R4: A start with length-select high runs 8 decisions and holds busy for 8*STEP_CYCLES cycles. Result bits 11..4 hold the converted code, bit 3 reads 1 and bits 2..0 read 0.
- R5: The length-select input is sampled only on the start cycle. Changing it during a conversion does not alter the length or the result.
- R6: A start pulse while busy is high neither restarts nor extends the running conversion.
- R7: The short-end pulse lasts one cycle and appears with the completion of the 8th decision in both modes. The full-end pulse lasts one cycle, appears with the completion of the 12th decision, and never appears in 8-bit mode. Both are visible in the cycle where busy has just fallen (or, for the short pulse in 12-bit mode, mid-run).
- R8: The result register keeps its previous value for the whole conversion and changes only in the cycle after the final decision.
- R9: The comparator input is used only on the last cycle of each step. Its value on the other cycles of a step has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle conversion request |
| short_sel | input | 1 | Length select captured at start: 0 = 12 bits, 1 = 8 bits |
| cmp_in | input | 1 | Comparator: 1 when analog input is at or above the DAC level |
| dac_code | output | 12 | Current trial code for the DAC |
| busy | output | 1 | High while a conversion is in progress |
| result | output | 12 | Last completed conversion code |
| eoc_short | output | 1 | One-cycle pulse when the 8th decision completes |
| eoc_full | output | 1 | One-cycle pulse when the 12th decision completes |

## Verification
The assertions assume that start and short_sel are clean synchronous levels and that reset is asserted at the first clock edge. The stimulus drives every input on the falling edge, releases reset before the first request, and never leaves start high longer than a cycle except when it deliberately pulses start during busy. The comparator is modelled as a compare of a fixed input code against dac_code. In one scenario the comparator is driven to the wrong answer on every cycle but the last of each step, which shows that only the sampling cycle matters.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int NBITS       = 12,
  parameter int SHORT_BITS  = 8,
  parameter int STEP_CYCLES = 200
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             short_sel,
  input  logic             cmp_in,
  output logic [NBITS-1:0] dac_code,
  output logic             busy,
  output logic [NBITS-1:0] result,
  output logic             eoc_short,
  output logic             eoc_full
);
  localparam int IW = $clog2(NBITS);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [IW-1:0] TOP_IDX   = IW'(NBITS - 1);
  localparam logic [IW-1:0] SHORT_IDX = IW'(NBITS - SHORT_BITS);
  localparam logic [CW-1:0] CNT_LAST  = CW'(STEP_CYCLES - 1);

  logic             busy_q, len_q, eoc8_q, eoc12_q;
  logic [IW-1:0]    idx_q;
  logic [CW-1:0]    cnt_q;
  logic [NBITS-1:0] trial_q, result_q, trial_nxt;
  logic             decide, last;

  assign decide    = busy_q && (cnt_q == CNT_LAST);
  assign last      = idx_q == (len_q ? SHORT_IDX : '0);
  assign dac_code  = trial_q;
  assign busy      = busy_q;
  assign result    = result_q;
  assign eoc_short = eoc8_q;
  assign eoc_full  = eoc12_q;

  always_comb begin
    trial_nxt = trial_q;
    if (!cmp_in) trial_nxt[idx_q] = 1'b0;
    if (idx_q != '0) trial_nxt[idx_q - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      len_q    <= 1'b0;
      idx_q    <= '0;
      cnt_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
      eoc8_q   <= 1'b0;
      eoc12_q  <= 1'b0;
    end else begin
      eoc8_q  <= 1'b0;
      eoc12_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q  <= 1'b1;
          len_q   <= short_sel;
          idx_q   <= TOP_IDX;
          cnt_q   <= '0;
          trial_q <= {1'b1, {(NBITS-1){1'b0}}};
        end
      end else if (decide) begin
        trial_q <= trial_nxt;
        cnt_q   <= '0;
        eoc8_q  <= (idx_q == SHORT_IDX);
        eoc12_q <= (idx_q == '0);
        if (last) begin
          busy_q   <= 1'b0;
          result_q <= trial_nxt;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R3: first trial after start has only the MSB set
  a_r3_msb_first: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> dac_code == {1'b1, {(NBITS-1){1'b0}}});

  // R6: a start during a non-final cycle keeps the run going with the same length
  a_r6_no_restart: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !(decide && last)) |=> (busy && $stable(len_q)));

  // R7: busy falls together with the end pulse of the selected length
  a_r7_end_pulse: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (len_q ? (eoc_short && !eoc_full) : eoc_full));

  // R7: pulses last one cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (eoc_short || eoc_full) |=> !(eoc_short || eoc_full));

  // R8: result frozen while a conversion is running
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(result));

  // R4: residue pattern after a short run
  a_r4_residue: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && len_q) |-> result[NBITS-SHORT_BITS-1:0] == {1'b1, {(NBITS-SHORT_BITS-1){1'b0}}});
endmodule

// File: tb/sar_seq_bench.sv
module sar_seq_bench;
  localparam int STEP = 5;
  logic clk = 1'b0;
  logic rst, start, short_sel, cmp_in;
  logic [11:0] dac_code, result;
  logic busy, eoc_short, eoc_full;
  logic [11:0] vin;
  logic corrupt;
  int bc;
  int n_checks = 0, n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sar_seq #(.NBITS(12), .SHORT_BITS(8), .STEP_CYCLES(STEP)) u_sar_seq (
    .clk(clk), .rst(rst), .start(start), .short_sel(short_sel), .cmp_in(cmp_in),
    .dac_code(dac_code), .busy(busy), .result(result),
    .eoc_short(eoc_short), .eoc_full(eoc_full));

  always @(posedge clk) begin
    if (start && !busy) bc <= 0;
    else bc <= bc + 1;
  end

  always_comb begin
    cmp_in = (vin >= dac_code);
    if (corrupt && (bc % STEP != STEP - 1)) cmp_in = ~cmp_in;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // one conversion; inj: pulse start with flipped short_sel mid-run (R5, R6)
  task automatic run_conv(input logic [11:0] v, input logic sel, input bit inj, input string req);
    logic [11:0] prev, exp;
    int nbusy, n8, n12, pos8;
    bit held;
    prev = result;
    vin = v;
    @(negedge clk); start = 1'b1; short_sel = sel;
    @(negedge clk); start = 1'b0;
    check(dac_code == 12'h800, "R3 first trial", dac_code, 12'h800);
    nbusy = 0; n8 = 0; n12 = 0; pos8 = -1; held = 1;
    while (busy) begin
      nbusy++;
      if (result != prev) held = 0;
      if (inj && nbusy == 7) begin start = 1'b1; short_sel = ~sel; end
      if (inj && nbusy == 8) start = 1'b0;
      if (inj && nbusy == 9) short_sel = sel;
      @(negedge clk);
      if (eoc_short) begin n8++; pos8 = nbusy; end
      if (eoc_full) n12++;
    end
    exp = sel ? {v[11:4], 4'b1000} : v;
    check(held, "R8 result held", 0, 0);
    check(nbusy == (sel ? 8 : 12) * STEP, {req, " busy length"}, nbusy, (sel ? 8 : 12) * STEP);
    check(result == exp, {req, " result"}, result, exp);
    check(n8 == 1 && pos8 == 8 * STEP, "R7 short pulse", pos8, 8 * STEP);
    check(n12 == (sel ? 0 : 1), "R7 full pulse", n12, sel ? 0 : 1);
    @(negedge clk);
    check(!eoc_short && !eoc_full, "R7 pulse width", {eoc_short, eoc_full}, 0);
  endtask

  task automatic t_reset();
    check(!busy && !eoc_short && !eoc_full, "R1 flags", {busy, eoc_short, eoc_full}, 0);
    check(result == 0 && dac_code == 0, "R1 regs", result, 0);
  endtask

  task automatic t_full();
    run_conv(12'hA5C, 1'b0, 0, "R2");
    run_conv(12'h000, 1'b0, 0, "R2");
    run_conv(12'hFFF, 1'b0, 0, "R2");
    run_conv(12'h800, 1'b0, 0, "R2");
    run_conv(12'h7FF, 1'b0, 0, "R2");
  endtask

  task automatic t_short();
    run_conv(12'h3C7, 1'b1, 0, "R4");
    run_conv(12'hFFF, 1'b1, 0, "R4");
    run_conv(12'h000, 1'b1, 0, "R4");
  endtask

  task automatic t_busy_start();
    run_conv(12'h5A3, 1'b0, 1, "R5 R6");
    run_conv(12'hC31, 1'b1, 1, "R5 R6");
  endtask

  task automatic t_sample_point();
    corrupt = 1'b1;
    run_conv(12'h6B9, 1'b0, 0, "R9");
    run_conv(12'h1E4, 1'b1, 0, "R9");
    corrupt = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; short_sel = 1'b0; vin = '0; corrupt = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_full();
    t_short();
    t_busy_start();
    t_sample_point();
    finish_run();
  end
endmodule